// File: doc/BRIEF.md
# Probabilistic Writeback Replication Selector

When a core's first-level cache evicts a dirty block, this block chooses where the data goes. Either the data is written into that core's own private second-level cache as a marked replica, or it is sent clockwise around a ring of private second-level caches until it finds a node that already holds the block. The choice is random. Its probability comes from a replication-level input, so the policy logic above can trade on-chip capacity against access latency by moving a single knob.

A decision starts when a writeback is accepted. The level is captured once, at that point, and a free-running pseudo-random draw is compared against a mask for that level. A replica decision produces a single local-write pulse that carries a marker and the captured level. A ring decision produces one hop per cycle. Each hop queries one node, which answers in the same cycle whether it holds a copy. The walk stops on the first holder, where the data merges. If every other node misses, the walk ends in a writeback to memory. While a decision is in progress, `busy` holds off new requests.

Top module: `wb_repl_selector`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `local_wr_valid`, `hop_valid`, `ring_merge` and `mem_wb_valid` are all low.
- R2: The draw comes from a 16-bit shift register. Reset loads 16'hACE1. In every clock cycle after reset it becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}. A request uses the value held during the cycle in which it is accepted, and the register never reaches zero.
- R3: The level is treated as min(level, 5). Level 0 never replicates. Level 1 replicates when draw[5:0]==0, level 2 when draw[3:0]==0, level 3 when draw[1:0]==0 and level 4 when draw[0]==0. Level 5 always replicates, so inputs 6 and 7 behave as 5.
- R4: On a replicate decision, `local_wr_valid` is high for exactly the one cycle after acceptance. In that cycle `local_wr_mark` is 1, `local_wr_level` is the saturated captured level, and `cur_core` and `cur_tag` give the request. No hop takes place.
- R5: On a ring decision, hops start the cycle after acceptance, one per cycle. They visit nodes origin+1, origin+2, … modulo 8, and `cur_tag` holds the request tag throughout.
- R6: If `hop_present` is high during a hop, `ring_merge` is high in that same cycle, the walk stops, and `busy` is low the next cycle.
- R7: The origin node is never probed. If all seven other nodes miss, `mem_wb_valid` is high for the one cycle after the last hop, and `busy` is low after that.
- R8: The level is sampled only at acceptance. Changing `req_level` during a decision changes neither its outcome nor `local_wr_level`.
- R9: `busy` is high from the cycle after acceptance through the last output cycle. A request presented while `busy` is high is not accepted and does not disturb `cur_core` or `cur_tag`. At most one of `local_wr_valid`, `hop_valid` and `mem_wb_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Writeback request present |
| req_core | input | 3 | Originating core / ring node |
| req_tag | input | 20 | Block tag of the writeback |
| req_level | input | 3 | Current replication level (0..7, saturates at 5) |
| busy | output | 1 | Decision in progress; requests are not accepted |
| cur_core | output | 3 | Originating core of the decision in progress |
| cur_tag | output | 20 | Tag of the decision in progress |
| local_wr_valid | output | 1 | Write the block into the originating core's own cache |
| local_wr_mark | output | 1 | Replica marker bit for the local write |
| local_wr_level | output | 3 | Level the replica was created under |
| hop_valid | output | 1 | A ring hop is probing node `hop_node` |
| hop_node | output | 3 | Node probed by the current hop |
| hop_present | input | 1 | The probed node holds a copy (same cycle) |
| ring_merge | output | 1 | Ring writeback merges at the probed node |
| mem_wb_valid | output | 1 | No copy on chip; write back to memory |

## Verification
The bench keeps its own model of the pseudo-random sequence and predicts every decision exactly, including the rare 1/64 cases. A wrong mask or off-by-one draw timing therefore shows up as an unexpected local write or hop. The ring walk is checked from each origin, including the wrap from node 7 to node 0. The bench also runs a walk in which only the origin holds a copy: a design that probed the origin would merge there instead of going to memory. Two tests change the level and hold the request high in the middle of a decision. A design that resampled the level or accepted a request while busy would alter the outcome or the reported tag.

// File: rtl/repl_pkg.sv
package repl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCAL = 2'd1,
    ST_RING  = 2'd2,
    ST_MEM   = 2'd3
  } sel_state_e;

  localparam int          LVL_W   = 3;
  localparam int          DRAW_W  = 6;
  localparam logic [2:0]  LVL_TOP = 3'd5;

  // bits of the draw that must all be zero for a replica at a given level
  function automatic logic [DRAW_W-1:0] lvl_mask(input logic [LVL_W-1:0] lvl);
    case (lvl)
      3'd1:    lvl_mask = 6'b11_1111;
      3'd2:    lvl_mask = 6'b00_1111;
      3'd3:    lvl_mask = 6'b00_0011;
      3'd4:    lvl_mask = 6'b00_0001;
      default: lvl_mask = 6'b00_0000;
    endcase
  endfunction

endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int          W     = 16,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter int          OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] draw
);

  logic [W-1:0] s_q, s_d;

  always_comb begin
    s_d = {s_q[W-2:0], ^(s_q & TAPS[W-1:0])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= SEED[W-1:0];
    else        s_q <= s_d;
  end

  assign draw = s_q[OUT_W-1:0];

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_q != '0);

endmodule

// File: rtl/repl_decide.sv
module repl_decide
  import repl_pkg::*;
(
  input  logic [DRAW_W-1:0] draw,
  input  logic [LVL_W-1:0]  level,
  output logic              replicate,
  output logic [LVL_W-1:0]  level_sat
);

  logic [DRAW_W-1:0] mask;

  always_comb begin
    level_sat = (level > LVL_TOP) ? LVL_TOP : level;
    mask      = lvl_mask(level_sat);
    if (level_sat == '0)           replicate = 1'b0;
    else if (level_sat == LVL_TOP) replicate = 1'b1;
    else                           replicate = ((draw & mask) == '0);
  end

endmodule

// File: rtl/repl_ring_ctl.sv
module repl_ring_ctl
  import repl_pkg::*;
#(
  parameter int N_CORES = 8,
  parameter int NODE_W  = $clog2(N_CORES),
  parameter int TAG_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_repl,
  input  logic [NODE_W-1:0] start_core,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic [LVL_W-1:0]  start_level,
  input  logic              hop_present,
  output logic              busy,
  output logic [NODE_W-1:0] cur_core,
  output logic [TAG_W-1:0]  cur_tag,
  output logic              local_wr_valid,
  output logic [LVL_W-1:0]  local_wr_level,
  output logic              hop_valid,
  output logic [NODE_W-1:0] hop_node,
  output logic              ring_merge,
  output logic              mem_wb_valid
);

  localparam logic [NODE_W-1:0] LAST_NODE = NODE_W'(N_CORES - 1);

  function automatic logic [NODE_W-1:0] ring_next(input logic [NODE_W-1:0] n);
    ring_next = (n == LAST_NODE) ? '0 : n + 1'b1;
  endfunction

  sel_state_e        st_q, st_d;
  logic [NODE_W-1:0] core_q, node_q, node_d;
  logic [TAG_W-1:0]  tag_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              cap_en;
  logic              last_hop;

  assign cap_en   = start && (st_q == ST_IDLE);
  assign last_hop = (ring_next(node_q) == core_q);

  always_comb begin
    st_d   = st_q;
    node_d = node_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = start_repl ? ST_LOCAL : ST_RING;
        node_d = ring_next(start_core);
      end
      ST_LOCAL: st_d = ST_IDLE;
      ST_RING: begin
        if (hop_present)   st_d = ST_IDLE;
        else if (last_hop) st_d = ST_MEM;
        else               node_d = ring_next(node_q);
      end
      ST_MEM:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      node_q <= '0;
    end else begin
      st_q   <= st_d;
      node_q <= node_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      tag_q  <= '0;
      lvl_q  <= '0;
    end else if (cap_en) begin
      core_q <= start_core;
      tag_q  <= start_tag;
      lvl_q  <= start_level;
    end
  end

  assign busy           = (st_q != ST_IDLE);
  assign cur_core       = core_q;
  assign cur_tag        = tag_q;
  assign local_wr_valid = (st_q == ST_LOCAL);
  assign local_wr_level = lvl_q;
  assign hop_valid      = (st_q == ST_RING);
  assign hop_node       = node_q;
  assign ring_merge     = hop_valid && hop_present;
  assign mem_wb_valid   = (st_q == ST_MEM);

  // R4
  local_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_wr_valid |=> !local_wr_valid);

  // R5
  hop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && !hop_present && (int'(hop_node) != (int'(cur_core) + N_CORES - 1) % N_CORES))
    |=> (hop_valid && int'(hop_node) == (int'($past(hop_node)) + 1) % N_CORES));

  // R6
  merge_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_merge |=> !busy);

  // R7
  skip_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> hop_node != cur_core);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cur_tag) && $stable(cur_core));

  // R9
  one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({local_wr_valid, hop_valid, mem_wb_valid}));

endmodule

// File: rtl/wb_repl_selector.sv
module wb_repl_selector
  import repl_pkg::*;
#(
  parameter int N_CORES = 8,
  parameter int NODE_W  = $clog2(N_CORES),
  parameter int TAG_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NODE_W-1:0] req_core,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [2:0]        req_level,
  output logic              busy,
  output logic [NODE_W-1:0] cur_core,
  output logic [TAG_W-1:0]  cur_tag,
  output logic              local_wr_valid,
  output logic              local_wr_mark,
  output logic [2:0]        local_wr_level,
  output logic              hop_valid,
  output logic [NODE_W-1:0] hop_node,
  input  logic              hop_present,
  output logic              ring_merge,
  output logic              mem_wb_valid
);

  logic [DRAW_W-1:0] draw;
  logic              replicate;
  logic [LVL_W-1:0]  lvl_sat;
  logic              accept;

  assign accept = req_valid && !busy;

  repl_lfsr #(.OUT_W(DRAW_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .draw  (draw)
  );

  repl_decide u_decide (
    .draw      (draw),
    .level     (req_level),
    .replicate (replicate),
    .level_sat (lvl_sat)
  );

  repl_ring_ctl #(.N_CORES(N_CORES), .NODE_W(NODE_W), .TAG_W(TAG_W)) u_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (req_valid),
    .start_repl     (replicate),
    .start_core     (req_core),
    .start_tag      (req_tag),
    .start_level    (lvl_sat),
    .hop_present    (hop_present),
    .busy           (busy),
    .cur_core       (cur_core),
    .cur_tag        (cur_tag),
    .local_wr_valid (local_wr_valid),
    .local_wr_level (local_wr_level),
    .hop_valid      (hop_valid),
    .hop_node       (hop_node),
    .ring_merge     (ring_merge),
    .mem_wb_valid   (mem_wb_valid)
  );

  assign local_wr_mark = local_wr_valid;

  // R3
  lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_level == 3'd0) |=> (hop_valid && !local_wr_valid));

  // R3
  lvl_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_level >= 3'd5) |=> (local_wr_valid && local_wr_level == 3'd5));

  // R8
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_wr_valid |-> local_wr_level <= 3'd5);

endmodule

// File: tb/sim_wb_repl_selector.sv
`timescale 1ns/1ps
module sim_wb_repl_selector;

  localparam int TW = 20;

  logic          clk, rst_n;
  logic          req_valid;
  logic [2:0]    req_core;
  logic [TW-1:0] req_tag;
  logic [2:0]    req_level;
  logic          busy, local_wr_valid, local_wr_mark, hop_valid, hop_present;
  logic          ring_merge, mem_wb_valid;
  logic [2:0]    cur_core, local_wr_level, hop_node;
  logic [TW-1:0] cur_tag;
  logic [7:0]    pres_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  wb_repl_selector u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_tag(req_tag), .req_level(req_level), .busy(busy), .cur_core(cur_core),
    .cur_tag(cur_tag), .local_wr_valid(local_wr_valid), .local_wr_mark(local_wr_mark),
    .local_wr_level(local_wr_level), .hop_valid(hop_valid), .hop_node(hop_node),
    .hop_present(hop_present), .ring_merge(ring_merge), .mem_wb_valid(mem_wb_valid)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // behavioural stand-in for per-node copy lookup
  assign hop_present = hop_valid && pres_mask[hop_node];

  // model of the draw sequence from R2
  logic [15:0] m_lfsr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  function automatic bit exp_repl(input logic [15:0] d, input logic [2:0] lvl);
    case (lvl)
      3'd0: exp_repl = 1'b0;
      3'd1: exp_repl = (d[5:0] == 6'd0);
      3'd2: exp_repl = (d[3:0] == 4'd0);
      3'd3: exp_repl = (d[1:0] == 2'd0);
      3'd4: exp_repl = (d[0] == 1'b0);
      default: exp_repl = 1'b1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // one writeback decision, checked cycle by cycle
  task automatic t_wb(input logic [2:0] core, input logic [TW-1:0] tag,
                      input logic [2:0] lvl, input logic [7:0] pres,
                      input bit hold, input logic [2:0] lvl_mid, output bit was_repl);
    bit er, merged;
    logic [2:0] el;
    pres_mask = pres;
    chk(busy == 1'b0, "R9 idle before request", busy, 0);
    chk(m_lfsr != 16'd0, "R2 draw nonzero", m_lfsr, 1);
    req_valid = 1; req_core = core; req_tag = tag; req_level = lvl;
    er = exp_repl(m_lfsr, lvl);
    el = (lvl > 3'd5) ? 3'd5 : lvl;
    was_repl = er;
    @(negedge clk);
    req_level = lvl_mid;                         // R8 level change mid-decision
    if (hold) begin req_tag = ~tag; req_core = core + 3'd3; end else req_valid = 0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    chk(cur_core == core, "R4/R5 cur_core", cur_core, core);
    if (er) begin
      chk(local_wr_valid == 1'b1, "R3/R4 local write expected", local_wr_valid, 1);
      chk(local_wr_mark == 1'b1, "R4 replica marker", local_wr_mark, 1);
      chk(local_wr_level == el, "R4/R8 replica level", local_wr_level, el);
      chk(cur_tag == tag, "R4 tag", cur_tag, tag);
      chk(hop_valid == 1'b0, "R4 no hop on replica", hop_valid, 0);
      @(negedge clk);
    end else begin
      chk(local_wr_valid == 1'b0, "R3 no local write", local_wr_valid, 0);
      merged = 0;
      for (int step = 1; step < 8 && !merged; step++) begin
        logic [2:0] nd;
        nd = core + 3'(step);
        chk(hop_valid == 1'b1, "R5 hop active", hop_valid, 1);
        chk(hop_node == nd, "R5/R7 hop node", hop_node, nd);
        chk(cur_tag == tag, "R5/R9 hop tag", cur_tag, tag);
        chk(ring_merge == pres[nd], "R6 merge flag", ring_merge, pres[nd]);
        if (pres[nd]) merged = 1;
        @(negedge clk);
      end
      if (!merged) begin
        chk(mem_wb_valid == 1'b1, "R7 memory writeback", mem_wb_valid, 1);
        chk(cur_tag == tag, "R7 memory tag", cur_tag, tag);
        @(negedge clk);
      end
    end
    req_valid = 0;
    chk(busy == 1'b0, "R6/R7/R9 busy released", busy, 0);
    chk(local_wr_valid == 0 && hop_valid == 0 && mem_wb_valid == 0,
        "R9 outputs quiet after decision", {local_wr_valid, hop_valid, mem_wb_valid}, 0);
  endtask

  task automatic t_reset;
    rst_n = 0; req_valid = 0; req_core = 0; req_tag = 0; req_level = 0; pres_mask = 0;
    #1;
    chk(busy == 0 && local_wr_valid == 0 && hop_valid == 0 && ring_merge == 0 && mem_wb_valid == 0,
        "R1 outputs in reset", {busy, local_wr_valid, hop_valid, ring_merge, mem_wb_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && local_wr_valid == 0 && hop_valid == 0 && mem_wb_valid == 0,
        "R1 outputs after reset", {busy, local_wr_valid, hop_valid, mem_wb_valid}, 0);
  endtask

  task automatic t_fixed_levels;
    bit r;
    t_wb(3'd2, 20'h11111, 3'd0, 8'b0001_0000, 0, 3'd0, r);
    chk(r == 0, "R3 level 0 never replicates", r, 0);
    t_wb(3'd4, 20'h22222, 3'd5, 8'h00, 0, 3'd5, r);
    chk(r == 1, "R3 level 5 always replicates", r, 1);
    t_wb(3'd1, 20'h33333, 3'd6, 8'h00, 0, 3'd6, r);
    t_wb(3'd0, 20'h44444, 3'd7, 8'h00, 0, 3'd7, r);
  endtask

  task automatic t_probabilistic;
    bit r;
    int reps;
    for (int lv = 1; lv <= 4; lv++) begin
      reps = 0;
      for (int k = 0; k < 80; k++) begin
        logic [2:0] c;
        c = 3'(k);
        t_wb(c, 20'(k * 97 + lv), 3'(lv), 8'hFF, 0, 3'(lv), r);
        reps += int'(r);
        if (k % 3 == 0) @(negedge clk);         // vary draw phase
      end
      if (lv == 4) chk(reps > 10 && reps < 70, "R3 level 4 rate plausible", reps, 40);
      if (lv == 3) chk(reps < 50, "R3 level 3 rate plausible", reps, 20);
    end
  endtask

  task automatic t_ring_paths;
    bit r;
    t_wb(3'd1, 20'hABCDE, 3'd0, 8'b0010_0000, 0, 3'd0, r);  // R5 walk to node 5
    t_wb(3'd6, 20'h0F0F0, 3'd0, 8'b0000_0010, 0, 3'd0, r);  // R5 wrap 7 -> 0 -> 1
    t_wb(3'd3, 20'h55555, 3'd0, 8'b0000_1000, 0, 3'd0, r);  // R7 only origin holds copy
    t_wb(3'd7, 20'h66666, 3'd0, 8'h00, 0, 3'd0, r);         // R7 nowhere
  endtask

  task automatic t_level_change;
    bit r;
    t_wb(3'd5, 20'h77777, 3'd5, 8'h00, 0, 3'd0, r);         // R8 5 then 0
    t_wb(3'd2, 20'h88888, 3'd0, 8'h00, 0, 3'd5, r);         // R8 0 then 5
    chk(r == 0, "R8 ring kept after level raise", r, 0);
  endtask

  task automatic t_backpressure;
    bit r;
    t_wb(3'd0, 20'h99999, 3'd0, 8'h00, 1, 3'd5, r);         // R9 request held while busy
    t_wb(3'd4, 20'hAAAAA, 3'd5, 8'h00, 1, 3'd5, r);
  endtask

  initial begin
    t_reset();
    t_fixed_levels();
    t_ring_paths();
    t_level_change();
    t_backpressure();
    t_probabilistic();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule